// File: doc/BRIEF.md
# Serial ADC Sample Reader

This block sits on the host side of a three-wire serial link to a 12-bit sampling converter and reads one conversion result per frame. It produces an active-low chip-select and a serial clock divided down from the system clock, and it takes in one serial data line. Each frame starts with chip-select going low. Exactly sixteen serial clock periods follow, and the block shifts in one bit at every falling serial clock edge. When the frame closes, the low twelve bits of the word are delivered with a one-cycle valid strobe. If any of the four leading bits, which must be zero, reads as one, an error flag is raised.

A frame is requested either by a pulse on a start input or by an internal rate timer that runs while auto mode is enabled. A request that arrives while a frame is in flight, or while the enforced idle gap after a frame is running, is remembered. The next frame then starts as soon as the gap is over. The serial clock half period, the gap lengths and the rate period are parameters counted in system clocks.

Top module: `adc_rd_top`

## Requirements
- R1: After reset, csN and sclk are high and resultValid and frameErr are low.
- R2: With the block idle, a startReq sampled high makes csN low at the next clock edge. sclk stays high for HALF_DIV cycles after csN falls and then has its first falling edge.
- R3: A frame has exactly 16 sclk falling edges. During a frame, every low phase and every high phase of sclk lasts HALF_DIV system cycles. sclk changes only while csN is low.
- R4: sdata is sampled at each falling sclk edge and assembled MSB first into a 16-bit word whose bit 15 is the first bit received. result carries bits 11..0 of that word and changes only together with resultValid.
- R5: resultValid is a single-cycle pulse. It is high in exactly the cycle in which csN returns high, which comes after the high phase that follows the 16th falling edge.
- R6: frameErr is set with each result to the OR of bits 15..12 of the received word and holds between results.
- R7: Between two frames, csN stays high for at least max(QUIET_CYC, CSHIGH_CYC) + 1 cycles.
- R8: A startReq that arrives during a frame or during its gap is held as pending. The next frame's csN falls exactly max(QUIET_CYC, CSHIGH_CYC) + 1 cycles after csN rose. Several requests in that window start only one frame.
- R9: While autoEn is high, the rate timer requests a frame every RATE_CYC cycles. When a frame plus its gap is shorter than RATE_CYC, consecutive csN falls are exactly RATE_CYC cycles apart.
- R10: sclk is high whenever csN is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| startReq | input | 1 | Request one read frame |
| autoEn | input | 1 | Enable periodic frames from the rate timer |
| sdata | input | 1 | Serial data from the converter |
| csN | output | 1 | Active-low chip-select, registered |
| sclk | output | 1 | Serial clock, idles high, registered |
| result | output | 12 | Last received conversion result |
| resultValid | output | 1 | One-cycle strobe for a new result |
| frameErr | output | 1 | Leading bits of the last word were not all zero |

## Verification
csN falls one cycle after a start pulse in idle. The first sclk fall comes HALF_DIV cycles later, and every later sclk edge comes HALF_DIV cycles after the one before. resultValid, result and frameErr all change in the same cycle that csN rises, and a pending frame launches GAP+1 cycles after that. The bench drives inputs on falling clock edges and runs a converter model that reacts to the design's own csN and sclk edges. A monitor then compares run lengths, counted in falling-edge samples, against exactly those counts. This ties each result to the word the model sent in that frame, not to an absolute cycle number.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int DATA_BITS  = FRAME_BITS - LEAD_BITS;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_LOW,
    ST_HIGH,
    ST_GAP
  } rd_state_e;

  typedef struct packed {
    logic sampleBit;
    logic frameDone;
  } rd_strobe_t;
endpackage

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV   = 10,
  parameter int CSHIGH_CYC = 2,
  parameter int QUIET_CYC  = 12,
  parameter int RATE_CYC   = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       startReq,
  input  logic       autoEn,
  output logic       csN,
  output logic       sclk,
  output rd_strobe_t strobe
);
  localparam int GAP_CYC = (QUIET_CYC > CSHIGH_CYC) ? QUIET_CYC : CSHIGH_CYC;
  localparam int CNT_MAX = (HALF_DIV > GAP_CYC) ? HALF_DIV : GAP_CYC;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam int BIT_W   = $clog2(FRAME_BITS);

  rd_state_e   state, nextState;
  logic [CNT_W-1:0] cnt;
  logic [BIT_W-1:0] bitCnt;
  logic pending, rateTick, launch, phaseEnd, gapEnd, lastBit;

  assign phaseEnd = (cnt == CNT_W'(HALF_DIV - 1));
  assign gapEnd   = (cnt == CNT_W'(GAP_CYC - 1));
  assign lastBit  = (bitCnt == BIT_W'(FRAME_BITS - 1));
  assign launch   = (state == ST_IDLE) && (pending || startReq || rateTick);

  // rate timer, present only when a rate period is configured
  generate
    if (RATE_CYC > 0) begin : g_rate
      localparam int RATE_W = $clog2(RATE_CYC + 1);
      logic [RATE_W-1:0] rateCnt;
      assign rateTick = autoEn && (rateCnt == RATE_W'(RATE_CYC - 1));
      always_ff @(posedge clk) begin
        if (!rstN || !autoEn || rateTick) rateCnt <= '0;
        else                               rateCnt <= rateCnt + 1'b1;
      end
    end else begin : g_no_rate
      assign rateTick = 1'b0;
    end
  endgenerate

  always_comb begin
    nextState = state;
    strobe    = '0;
    unique case (state)
      ST_IDLE:  if (launch) nextState = ST_SETUP;
      ST_SETUP: if (phaseEnd) begin
        nextState        = ST_LOW;
        strobe.sampleBit = 1'b1;
      end
      ST_LOW:   if (phaseEnd) nextState = ST_HIGH;
      ST_HIGH:  if (phaseEnd) begin
        if (lastBit) begin
          nextState        = ST_GAP;
          strobe.frameDone = 1'b1;
        end else begin
          nextState        = ST_LOW;
          strobe.sampleBit = 1'b1;
        end
      end
      ST_GAP:   if (gapEnd) nextState = ST_IDLE;
      default:  nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      cnt     <= '0;
      bitCnt  <= '0;
      pending <= 1'b0;
      csN     <= 1'b1;
      sclk    <= 1'b1;
    end else begin
      state <= nextState;
      cnt   <= (nextState != state) ? '0 : cnt + 1'b1;
      if (launch)                                   bitCnt <= '0;
      else if (state == ST_HIGH && nextState == ST_LOW) bitCnt <= bitCnt + 1'b1;
      if (launch)                       pending <= 1'b0;
      else if (startReq || rateTick)    pending <= 1'b1;
      csN  <= (nextState == ST_IDLE) || (nextState == ST_GAP);
      sclk <= (nextState != ST_LOW);
    end
  end
endmodule

// File: rtl/adc_rd_dp.sv
module adc_rd_dp
  import adc_rd_pkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 sdata,
  input  rd_strobe_t           strobe,
  output logic [DATA_BITS-1:0] result,
  output logic                 resultValid,
  output logic                 frameErr
);
  logic [FRAME_BITS-1:0] shiftReg;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg    <= '0;
      result      <= '0;
      resultValid <= 1'b0;
      frameErr    <= 1'b0;
    end else begin
      if (strobe.sampleBit) shiftReg <= {shiftReg[FRAME_BITS-2:0], sdata};
      resultValid <= strobe.frameDone;
      if (strobe.frameDone) begin
        result   <= shiftReg[DATA_BITS-1:0];
        frameErr <= |shiftReg[FRAME_BITS-1:DATA_BITS];
      end
    end
  end
endmodule

// File: rtl/adc_rd_top.sv
module adc_rd_top
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV   = 10,
  parameter int CSHIGH_CYC = 2,
  parameter int QUIET_CYC  = 12,
  parameter int RATE_CYC   = 400
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        autoEn,
  input  logic        sdata,
  output logic        csN,
  output logic        sclk,
  output logic [11:0] result,
  output logic        resultValid,
  output logic        frameErr
);
  rd_strobe_t strobe;

  adc_rd_ctrl #(
    .HALF_DIV(HALF_DIV), .CSHIGH_CYC(CSHIGH_CYC),
    .QUIET_CYC(QUIET_CYC), .RATE_CYC(RATE_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .autoEn(autoEn),
    .csN(csN), .sclk(sclk), .strobe(strobe)
  );

  adc_rd_dp i_dp (
    .clk(clk), .rstN(rstN), .sdata(sdata), .strobe(strobe),
    .result(result), .resultValid(resultValid), .frameErr(frameErr)
  );
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk #(
  parameter int CSHIGH_CYC = 2,
  parameter int QUIET_CYC  = 12
) (
  input logic        clk,
  input logic        rstN,
  input logic        csN,
  input logic        sclk,
  input logic [11:0] result,
  input logic        resultValid,
  input logic        frameErr
);
  localparam int GAP_CYC = (QUIET_CYC > CSHIGH_CYC) ? QUIET_CYC : CSHIGH_CYC;
  localparam int SAT     = GAP_CYC + 1;
  localparam int RUN_W   = $clog2(SAT + 2);

  logic [RUN_W-1:0] highRun;
  always_ff @(posedge clk) begin
    if (!rstN)                   highRun <= RUN_W'(SAT);
    else if (!csN)               highRun <= '0;
    else if (highRun < RUN_W'(SAT)) highRun <= highRun + 1'b1;
  end

  p_sclk_idle_high_r10: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk);
  p_sclk_moves_in_frame_r3: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sclk) |-> !csN);
  p_cs_fall_sclk_high_r2: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> sclk);
  p_valid_one_cycle_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |=> !resultValid);
  p_cs_rise_gives_valid_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> resultValid);
  p_valid_only_at_cs_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    resultValid |-> $rose(csN));
  p_result_held_r4: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(result));
  p_err_held_r6: assert property (@(posedge clk) disable iff (!rstN)
    !resultValid |-> $stable(frameErr));
  p_cs_high_gap_r7: assert property (@(posedge clk) disable iff (!rstN)
    $fell(csN) |-> (highRun >= RUN_W'(SAT)));
endmodule

bind adc_rd_top adc_rd_chk #(
  .CSHIGH_CYC(CSHIGH_CYC), .QUIET_CYC(QUIET_CYC)
) i_chk (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .result(result),
  .resultValid(resultValid), .frameErr(frameErr)
);

// File: tb/test_adc_rd_top.sv
module test_adc_rd_top;
  localparam int HALF_DIV   = 10;
  localparam int CSHIGH_CYC = 2;
  localparam int QUIET_CYC  = 12;
  localparam int RATE_CYC   = 400;
  localparam int GAP_CYC    = (QUIET_CYC > CSHIGH_CYC) ? QUIET_CYC : CSHIGH_CYC;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic autoEn = 1'b0;
  logic sdata = 1'b1;
  logic csN, sclk, resultValid, frameErr;
  logic [11:0] result;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;
  logic [15:0] nextWord = 16'h0000;
  logic [15:0] curWord = 16'h0000;

  always #2.5 clk = ~clk;

  adc_rd_top #(
    .HALF_DIV(HALF_DIV), .CSHIGH_CYC(CSHIGH_CYC),
    .QUIET_CYC(QUIET_CYC), .RATE_CYC(RATE_CYC)
  ) i_adc_rd_top (
    .clk(clk), .rstN(rstN), .startReq(startReq), .autoEn(autoEn),
    .sdata(sdata), .csN(csN), .sclk(sclk), .result(result),
    .resultValid(resultValid), .frameErr(frameErr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  function automatic logic [15:0] genWord();
    logic [15:0] w;
    w = 16'($urandom);
    if (($urandom % 4) != 0) w[15:12] = 4'h0;
    return w;
  endfunction

  // converter model: first bit on select, next bit after each falling sclk
  initial begin
    forever begin
      @(negedge csN);
      curWord = nextWord;
      #2 sdata = curWord[15];
      for (int k = 14; k >= 0; k--) begin
        @(negedge sclk);
        #2 sdata = curWord[k];
      end
      @(negedge sclk);
      #2 sdata = 1'b1;
    end
  end

  // port monitor, samples on falling clock edges
  logic prevCs = 1'b1, prevSclk = 1'b1;
  int sclkRun = 0, csLowRun = 0, highRun = 1000, fallCnt = 0;
  int lastHigh = 0, frameCount = 0, lastFallCyc = 0;
  bit autoCheck = 1'b0, autoPrev = 1'b0;

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(1'b0, "watchdog", cyc, 150000);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
    if (rstN) begin
      if (prevCs && !csN) begin
        check(highRun >= GAP_CYC + 1, "R7 cs high gap", highRun, GAP_CYC + 1);
        lastHigh = highRun;
        fallCnt = 0;
        frameCount++;
        if (autoCheck && autoPrev)
          check(cyc - lastFallCyc == RATE_CYC, "R9 rate interval", cyc - lastFallCyc, RATE_CYC);
        autoPrev = autoCheck;
        lastFallCyc = cyc;
      end
      if (!prevCs && csN) begin
        check(fallCnt == 16, "R3 falling edges", fallCnt, 16);
        check(resultValid, "R5 valid at cs rise", resultValid, 1);
        check(result == curWord[11:0], "R4 result", result, curWord[11:0]);
        check(frameErr == (|curWord[15:12]), "R6 frameErr", frameErr, |curWord[15:12]);
      end else if (resultValid) begin
        check(1'b0, "R5 stray valid", 1, 0);
      end
      if (!csN && prevSclk && !sclk) begin
        if (fallCnt == 0) check(csLowRun == HALF_DIV, "R2 first fall delay", csLowRun, HALF_DIV);
        else              check(sclkRun == HALF_DIV, "R3 high phase", sclkRun, HALF_DIV);
        fallCnt++;
      end
      if (!csN && !prevSclk && sclk)
        check(sclkRun == HALF_DIV, "R3 low phase", sclkRun, HALF_DIV);
      if (csN && !sclk) check(1'b0, "R10 sclk low while idle", sclk, 1);
      if (csN != prevCs && sclk != prevSclk) check(1'b0, "R3 sclk moved with cs", sclk, prevSclk);
    end
    sclkRun  = (sclk == prevSclk) ? sclkRun + 1 : 1;
    csLowRun = csN ? 0 : (prevCs ? 1 : csLowRun + 1);
    highRun  = !csN ? 0 : (prevCs ? highRun + 1 : 1);
    if (!autoCheck) autoPrev = 1'b0;
    prevCs = csN;
    prevSclk = sclk;
  end

  task automatic pulseStart();
    @(negedge clk) startReq = 1'b1;
    @(negedge clk) startReq = 1'b0;
  endtask

  task automatic waitCycles(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    int fc0;
    logic [15:0] directed [4];
    void'($urandom(32'd4242));
    directed[0] = 16'h0FFF; directed[1] = 16'h0000;
    directed[2] = 16'h8ABC; directed[3] = 16'h1555;
    waitCycles(4);
    rstN = 1'b1;
    waitCycles(2);
    // R1 reset state
    check(csN == 1'b1, "R1 csN", csN, 1);
    check(sclk == 1'b1, "R1 sclk", sclk, 1);
    check(resultValid == 1'b0, "R1 resultValid", resultValid, 0);
    check(frameErr == 1'b0, "R1 frameErr", frameErr, 0);

    // directed words, R2 launch latency, R6 error pattern
    for (int i = 0; i < 4; i++) begin
      nextWord = directed[i];
      pulseStart();
      check(csN == 1'b0, "R2 cs falls after start", csN, 0);
      waitCycles(400);
    end

    // R8 requests during a frame collapse into one pending frame
    nextWord = 16'h0123;
    pulseStart();
    waitCycles(3);
    fc0 = frameCount;
    waitCycles(50);
    pulseStart();
    waitCycles(100);
    pulseStart();
    waitCycles(900);
    check(frameCount == fc0 + 1, "R8 single pending frame", frameCount, fc0 + 1);
    check(lastHigh == GAP_CYC + 1, "R8 pending launch gap", lastHigh, GAP_CYC + 1);

    // R8 request during the gap
    nextWord = 16'h0456;
    pulseStart();
    @(posedge csN);
    waitCycles(3);
    pulseStart();
    waitCycles(400);
    check(lastHigh == GAP_CYC + 1, "R8 gap request launch", lastHigh, GAP_CYC + 1);

    // random starts, including some landing in frames
    for (int i = 0; i < 25; i++) begin
      nextWord = genWord();
      waitCycles($urandom % 400);
      pulseStart();
    end
    waitCycles(800);

    // R9 rate timer
    autoCheck = 1'b1;
    autoEn = 1'b1;
    repeat (6) begin
      @(negedge csN);
      #1 nextWord = genWord();
    end
    waitCycles(2);
    autoCheck = 1'b0;
    autoEn = 1'b0;
    waitCycles(800);
    check(csN == 1'b1, "R9 idle after auto off", csN, 1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule